// File: doc/BRIEF.md
# DMA Channel Enable and Request Status Register

This block holds the control word for one DMA channel and decides, cycle by cycle, whether that channel may move data. A processor-side port writes the whole 32-bit word in one access and reads it back at any time. Four bits in the word are live: a channel enable, a synchronized copy of the request line, a select bit that lets the end of a transfer clear the enable, and a self-clearing bit that sends a clear pulse to the channel's status logic. Every other bit reads as zero.

The rest of the channel sees two outputs. `xfer_ok` permits the bus engine to perform operands. `stat_clr` is a one-cycle pulse that resets the channel's internal status. The request status bit follows the request line whether or not the channel is enabled. When software turns the channel off during an active transfer, the channel does not stop at once: it keeps permission until the current operand completes. When the select bit is set, the end-of-transfer condition turns the enable off directly, and this hardware clear takes priority over a software write in the same cycle.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, `rd_data` is all zero and `xfer_ok` and `stat_clr` are 0.
- R2: Bit 24 of the word is the channel enable. A write stores `wr_data[24]` there, and the new value reads back from the next cycle on.
- R3: Bit 8 is a read/write auto-clear select. When it is 1, a `xfer_end` pulse clears bit 24 from the next cycle on. When it is 0, `xfer_end` leaves bit 24 unchanged.
- R4: If a `xfer_end` pulse with bit 8 set arrives in the same cycle as a write of 1 to bit 24, bit 24 reads 0 afterwards.
- R5: When no stop is pending, `xfer_ok` is 1 exactly when bit 24 and bit 16 both read 1.
- R6: Bit 16 shows the level of `req_in` two clock edges after that level is applied. It follows `req_in` even while bit 24 is 0.
- R7: If a write clears bit 24 while `xfer_ok` is 1 and `opnd_done` is low, `xfer_ok` stays 1 (while the request holds) until an `opnd_done` pulse. It reads 0 from the cycle after that pulse.
- R8: A write with bit 0 set raises `stat_clr` for exactly one cycle, starting the cycle after the write. Bit 0 reads 1 during that cycle only and 0 afterwards.
- R9: Bits 31–25, 23–17, 15–9 and 7–1 always read 0, even after a write of all ones.
- R10: A write that clears bit 24 while `xfer_ok` is 0 leaves `xfer_ok` at 0. A later request does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| req_in | input | 1 | Asynchronous DMA request line |
| xfer_end | input | 1 | End-of-transfer condition pulse from the channel counter |
| opnd_done | input | 1 | Operand-complete pulse from the bus engine |
| xfer_ok | output | 1 | Channel permitted to transfer |
| stat_clr | output | 1 | One-cycle channel status clear pulse |

## Verification
A stop-pending flag that is set wrongly or left stuck shows as `xfer_ok` staying high after the operand pulse, or dropping before it. The bench sees this in the cycle after `opnd_done`, or in the cycle after the disabling write. A wrong enable-update priority shows on bit 24 in the read data one cycle after the colliding `xfer_end`. A synchronizer with the wrong depth moves bit 16 by a cycle, and the bench catches this by sampling the bit exactly two edges after each change of the request line. A clear pulse that sticks, or that is lost, shows on `stat_clr` and bit 0 within one cycle of the write.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
   typedef struct packed {
      logic den;
      logic req;
      logic aclr;
      logic sclr;
   } dcc_fields_t;

   function automatic int unsigned dcc_min_stages();
      return 2;
   endfunction
endpackage

// File: rtl/dcc_sync.sv
`timescale 1ns/1ps
module dcc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dcc_en_ctl.sv
`timescale 1ns/1ps
module dcc_en_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_den,
   input  logic aclr_sel,
   input  logic xfer_end,
   input  logic opnd_done,
   input  logic req_s,
   output logic den_q,
   output logic xfer_ok
);
   logic stop_pend_q;
   logic hw_clr;

   assign hw_clr  = xfer_end & aclr_sel;
   assign xfer_ok = (den_q | stop_pend_q) & req_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         den_q       <= 1'b0;
         stop_pend_q <= 1'b0;
      end else if (hw_clr) begin
         den_q       <= 1'b0;
         stop_pend_q <= 1'b0;
      end else if (wr_en) begin
         den_q       <= wr_den;
         stop_pend_q <= ~wr_den & xfer_ok & ~opnd_done;
      end else if (opnd_done) begin
         stop_pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dcc_clr_pulse.sv
`timescale 1ns/1ps
module dcc_clr_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= fire;
   end
endmodule

// File: rtl/dma_chan_ctl.sv
`timescale 1ns/1ps
module dma_chan_ctl #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned EN_BIT      = 24,
   parameter int unsigned REQ_BIT     = 16,
   parameter int unsigned ACLR_BIT    = 8,
   parameter int unsigned SCLR_BIT    = 0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              req_in,
   input  logic              xfer_end,
   input  logic              opnd_done,
   output logic              xfer_ok,
   output logic              stat_clr
);
   import dcc_pkg::*;

   localparam int unsigned MAX_BIT = DATA_W - 1;

   generate
      if (SYNC_STAGES < dcc_min_stages()) begin : g_bad_sync
         $error("dma_chan_ctl: SYNC_STAGES must be at least 2");
      end
      if (EN_BIT > MAX_BIT || REQ_BIT > MAX_BIT ||
          ACLR_BIT > MAX_BIT || SCLR_BIT > MAX_BIT) begin : g_bad_pos
         $error("dma_chan_ctl: field position outside the word");
      end
      if (EN_BIT == REQ_BIT || EN_BIT == ACLR_BIT || EN_BIT == SCLR_BIT ||
          REQ_BIT == ACLR_BIT || REQ_BIT == SCLR_BIT ||
          ACLR_BIT == SCLR_BIT) begin : g_bad_overlap
         $error("dma_chan_ctl: field positions overlap");
      end
   endgenerate

   dcc_fields_t fld;
   logic        aclr_q;

   dcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(req_in),
      .q_sync (fld.req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     aclr_q <= 1'b0;
      else if (wr_en) aclr_q <= wr_data[ACLR_BIT];
   end
   assign fld.aclr = aclr_q;

   dcc_en_ctl u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_den   (wr_data[EN_BIT]),
      .aclr_sel (aclr_q),
      .xfer_end (xfer_end),
      .opnd_done(opnd_done),
      .req_s    (fld.req),
      .den_q    (fld.den),
      .xfer_ok  (xfer_ok)
   );

   dcc_clr_pulse u_clr (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (wr_en & wr_data[SCLR_BIT]),
      .pulse_q(fld.sclr)
   );
   assign stat_clr = fld.sclr;

   always_comb begin
      rd_data           = '0;
      rd_data[EN_BIT]   = fld.den;
      rd_data[REQ_BIT]  = fld.req;
      rd_data[ACLR_BIT] = fld.aclr;
      rd_data[SCLR_BIT] = fld.sclr;
   end
endmodule

// File: rtl/dcc_chk.sv
`timescale 1ns/1ps
module dcc_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned EN_BIT   = 24,
   parameter int unsigned REQ_BIT  = 16,
   parameter int unsigned ACLR_BIT = 8,
   parameter int unsigned SCLR_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              xfer_end,
   input logic              xfer_ok,
   input logic              stat_clr
);
   // R5 / R7: permission never exists without a synchronized request
   p_permit_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ok |-> rd_data[REQ_BIT]);

   // R3: end condition with auto-clear selected drops the enable
   p_auto_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_end && rd_data[ACLR_BIT]) |=> !rd_data[EN_BIT]);

   // R2: a write without a colliding hardware clear stores the enable bit
   p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(xfer_end && rd_data[ACLR_BIT])) |=> (rd_data[EN_BIT] == $past(wr_data[EN_BIT])));

   // R8: a clear request yields a pulse in the next cycle
   p_clr_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[SCLR_BIT]) |=> stat_clr);

   // R8: the pulse lasts one cycle unless requested again
   p_clr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !(wr_en && wr_data[SCLR_BIT])) |=> !stat_clr);
endmodule

bind dma_chan_ctl dcc_chk #(
   .DATA_W  (DATA_W),
   .EN_BIT  (EN_BIT),
   .REQ_BIT (REQ_BIT),
   .ACLR_BIT(ACLR_BIT),
   .SCLR_BIT(SCLR_BIT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .xfer_end(xfer_end),
   .xfer_ok (xfer_ok),
   .stat_clr(stat_clr)
);

// File: tb/sim_dma_chan_ctl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        req_in = 1'b0;
   logic        xfer_end = 1'b0;
   logic        opnd_done = 1'b0;
   logic        xfer_ok;
   logic        stat_clr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   localparam logic [31:0] EN   = 32'h0100_0000;
   localparam logic [31:0] REQ  = 32'h0001_0000;
   localparam logic [31:0] ACLR = 32'h0000_0100;
   localparam logic [31:0] SCLR = 32'h0000_0001;

   always #2.5 clk = ~clk;

   dma_chan_ctl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .req_in(req_in), .xfer_end(xfer_end),
      .opnd_done(opnd_done), .xfer_ok(xfer_ok), .stat_clr(stat_clr)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL R0 watchdog: got %0d cycles expected fewer", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // advance one edge; inputs change and outputs are sampled at the falling edge
   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic set_req(input logic v);
      req_in = v; step(); step();
   endtask

   task automatic t_reset();
      chk("R1 rd_data", rd_data, 32'h0);
      chk("R1 xfer_ok", {31'b0, xfer_ok}, 32'h0);
      chk("R1 stat_clr", {31'b0, stat_clr}, 32'h0);
   endtask

   task automatic t_rw_rsvd();
      wr(32'hFFFF_FFFE);
      chk("R9 reserved zero", rd_data & ~(EN | REQ | ACLR | SCLR), 32'h0);
      chk("R2 enable set", rd_data & EN, EN);
      chk("R3 select readback", rd_data & ACLR, ACLR);
      wr(32'h0);
      chk("R2 enable clear", rd_data & EN, 32'h0);
   endtask

   task automatic t_req_sync();
      req_in = 1'b1; step();
      chk("R6 not yet after one edge", rd_data & REQ, 32'h0);
      step();
      chk("R6 request while disabled", rd_data & REQ, REQ);
      chk("R5 no permit while disabled", {31'b0, xfer_ok}, 32'h0);
      wr(EN);
      chk("R5 permit en and req", {31'b0, xfer_ok}, 32'h1);
      set_req(1'b0);
      chk("R6 request dropped", rd_data & REQ, 32'h0);
      chk("R5 permit follows req", {31'b0, xfer_ok}, 32'h0);
      wr(32'h0);
   endtask

   task automatic t_auto_clear();
      wr(EN);
      xfer_end = 1'b1; step(); xfer_end = 1'b0;
      chk("R3 no clear without select", rd_data & EN, EN);
      wr(EN | ACLR);
      xfer_end = 1'b1; step(); xfer_end = 1'b0;
      chk("R3 auto clear", rd_data & EN, 32'h0);
      xfer_end = 1'b1; wr_en = 1'b1; wr_data = EN | ACLR; step();
      xfer_end = 1'b0; wr_en = 1'b0; wr_data = '0;
      chk("R4 hardware clear wins", rd_data & EN, 32'h0);
      wr(32'h0);
   endtask

   task automatic t_soft_stop();
      set_req(1'b1);
      wr(EN);
      chk("R7 active before stop", {31'b0, xfer_ok}, 32'h1);
      wr(32'h0);
      chk("R7 enable reads 0", rd_data & EN, 32'h0);
      chk("R7 held for operand", {31'b0, xfer_ok}, 32'h1);
      step(); step();
      chk("R7 still held", {31'b0, xfer_ok}, 32'h1);
      opnd_done = 1'b1; step(); opnd_done = 1'b0;
      chk("R7 stop after operand", {31'b0, xfer_ok}, 32'h0);
      set_req(1'b0);
      wr(EN); wr(32'h0);
      chk("R10 idle disable", {31'b0, xfer_ok}, 32'h0);
      set_req(1'b1);
      chk("R10 no permit after idle disable", {31'b0, xfer_ok}, 32'h0);
      set_req(1'b0);
   endtask

   task automatic t_clr_pulse();
      wr(SCLR);
      chk("R8 pulse high", {31'b0, stat_clr}, 32'h1);
      chk("R8 bit reads 1", rd_data & SCLR, SCLR);
      step();
      chk("R8 pulse ends", {31'b0, stat_clr}, 32'h0);
      chk("R8 bit reads 0", rd_data & SCLR, 32'h0);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      t_reset();
      rst_n = 1'b1; step();
      t_reset();
      t_rw_rsvd();
      t_req_sync();
      t_auto_clear();
      t_soft_stop();
      t_clr_pulse();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule